// File: doc/BRIEF.md
# Global 64-bit comparator timer

This block is a memory-mapped 64-bit counter with one compare channel. Software reaches it through a plain single-cycle 32-bit register port. To set the time, software writes the counter's lower and upper halves. It then sets a start bit in the control register. From the next clock on, the counter advances by one on every cycle. When the start bit is clear, the counter holds its value and can still be loaded.

The compare channel keeps a 64-bit target. When the channel is enabled and the counter equals the target, the channel raises an interrupt status flag. The flag is set even when the interrupt is masked. With auto-increment on, each match adds a programmable step to the target. The target then moves ahead by that step after every hit, which gives a periodic interrupt.

Every write to a timing register is acknowledged by a sticky write-status bit. The bit appears one cycle after the write takes effect, and software clears it by writing a one to it.

Top module: `gcmp_timer`

## Requirements
- R1: After reset every readable register reads 0 and `irq` is low.
- R2: Writing offset 0x100 replaces the counter's lower 32 bits and writing 0x104 replaces its upper 32 bits. While control bit 8 is 0 the counter keeps its value.
- R3: While control bit 8 is 1 and no counter half is being written, the counter grows by one per clock, carrying from the lower half into the upper half.
- R4: The control register at 0x240 keeps only bit 8 (run), bit 1 (auto-increment) and bit 0 (compare enable). All its other bits read 0.
- R5: On a clock edge where compare enable is 1 and the counter equals the 64-bit target (low half at 0x200, high half at 0x204), bit 0 of the interrupt status at 0x244 becomes 1. This happens whatever the interrupt enable is.
- R6: On such a match with auto-increment on, the target becomes target plus the step held at 0x208, unless the target is being written in the same cycle.
- R7: Writing 1 to bit 0 of 0x244 clears the interrupt status. A match in the same cycle keeps it set.
- R8: `irq` is high exactly when interrupt status bit 0 and bit 0 of the interrupt enable at 0x248 are both 1.
- R9: One cycle after a write takes effect, a sticky bit is set in the write-status register at 0x24C: bit 16 for control, bit 0 for target low, bit 1 for target high, bit 2 for step. In the same way, 0x110 bit 0 is set for counter low and bit 1 for counter high.
- R10: Writing a mask to 0x24C or 0x110 clears the bits that are 1 in the mask and leaves the others unchanged.
- R11: Reads from any offset not listed above return 0.
- R12: In a cycle where a counter half is written, the written value is loaded exactly, and the counter does not increment in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Compare interrupt |

## Verification
The assertions assume that at most one register is written per cycle and that each write is a single-cycle strobe at an exact offset. They also assume that reset is held for at least one edge before it is released. The stimulus keeps within these assumptions by driving the bus from one sequential task: it changes address, data and strobe only on the falling edge and issues one access per call. The reference model then applies the same single access at each rising edge. This covers timing cases in which a counter load, a compare hit and a status clear might share a cycle; the model and the design must agree on which one wins.

// File: rtl/gcmp_pkg.sv
// Package: shared offsets and bit positions of the comparator timer.
// Assumes a 12-bit byte offset space and 32-bit data words.
package gcmp_pkg;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFF_CNT_LO  = 12'h100;
    localparam logic [ADDR_W-1:0] OFF_CNT_HI  = 12'h104;
    localparam logic [ADDR_W-1:0] OFF_CNT_WS  = 12'h110;
    localparam logic [ADDR_W-1:0] OFF_TGT_LO  = 12'h200;
    localparam logic [ADDR_W-1:0] OFF_TGT_HI  = 12'h204;
    localparam logic [ADDR_W-1:0] OFF_STEP    = 12'h208;
    localparam logic [ADDR_W-1:0] OFF_CTRL    = 12'h240;
    localparam logic [ADDR_W-1:0] OFF_ISTAT   = 12'h244;
    localparam logic [ADDR_W-1:0] OFF_IEN     = 12'h248;
    localparam logic [ADDR_W-1:0] OFF_MAIN_WS = 12'h24C;

    // control bit positions
    localparam int CTL_RUN  = 8;
    localparam int CTL_AUTO = 1;
    localparam int CTL_CEN  = 0;

    // write-status bit positions
    localparam int WS_CTRL   = 16;
    localparam int WS_TGT_LO = 0;
    localparam int WS_TGT_HI = 1;
    localparam int WS_STEP   = 2;
    localparam int WS_CNT_LO = 0;
    localparam int WS_CNT_HI = 1;
endpackage

// File: rtl/gcmp_counter.sv
// Module: 2*DATA_W-bit up-counter, loadable by halves.
// Assumes at most one half is written per cycle; a write suppresses counting.
module gcmp_counter #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [DATA_W-1:0]   wdata,
    output logic [2*DATA_W-1:0] cnt
);
    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0] cnt_q;

    // load a half on write, otherwise count while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) cnt_q[DATA_W-1:0]     <= wdata;
            if (wr_hi) cnt_q[CNT_W-1:DATA_W] <= wdata;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/gcmp_compare.sv
// Module: one compare channel with a 64-bit target and an auto-increment step.
// Assumes the counter value is registered; a target write beats auto-increment.
module gcmp_compare #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*DATA_W-1:0] cnt,
    input  logic                enable,
    input  logic                auto_inc,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic                wr_step,
    input  logic [DATA_W-1:0]   wdata,
    output logic [2*DATA_W-1:0] target,
    output logic [DATA_W-1:0]   step,
    output logic                hit
);
    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0]  tgt_q;
    logic [DATA_W-1:0] step_q;

    // equality against the current target while enabled
    always_comb begin
        hit = enable && (cnt == tgt_q);
    end

    // target update: software write first, then re-arm on hit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) tgt_q[DATA_W-1:0]     <= wdata;
            if (wr_hi) tgt_q[CNT_W-1:DATA_W] <= wdata;
        end else if (hit && auto_inc) begin
            tgt_q <= tgt_q + CNT_W'(step_q);
        end
    end

    // step register
    always_ff @(posedge clk) begin
        if (!rst_n)       step_q <= '0;
        else if (wr_step) step_q <= wdata;
    end

    assign target = tgt_q;
    assign step   = step_q;
endmodule

// File: rtl/gcmp_wstat.sv
// Module: sticky write-acknowledge bits, set one cycle after each request.
// Assumes requests are single-cycle pulses; set beats a same-cycle clear.
module gcmp_wstat #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_req,
    input  logic              clr_wr,
    input  logic [DATA_W-1:0] clr_mask,
    output logic [DATA_W-1:0] stat
);
    logic [DATA_W-1:0] pend_q;
    logic [DATA_W-1:0] stat_q;

    // delay requests by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= set_req;
    end

    // write-one-to-clear with set priority
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~(clr_wr ? clr_mask : '0)) | pend_q;
    end

    assign stat = stat_q;
endmodule

// File: rtl/gcmp_timer.sv
// Module: top of the comparator timer: register decode, control, interrupt.
// Assumes one single-cycle access per clock at exact offsets; reads are free of side effects.
module gcmp_timer #(
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [gcmp_pkg::ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    output logic                        irq
);
    import gcmp_pkg::*;

    localparam int CNT_W = 2 * DATA_W;

    logic wr_cnt_lo, wr_cnt_hi, wr_cnt_ws, wr_tgt_lo, wr_tgt_hi, wr_step;
    logic wr_ctrl, wr_istat, wr_ien, wr_main_ws;

    logic              run_q, auto_q, cen_q, istat_q, ien_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  tgt_q;
    logic [DATA_W-1:0] step_q;
    logic              hit;
    logic [DATA_W-1:0] main_set, cnt_set, main_ws, cnt_ws;
    logic [DATA_W-1:0] ctrl_view;

    // write strobe decode
    always_comb begin
        wr_cnt_lo  = bus_wr && (bus_addr == OFF_CNT_LO);
        wr_cnt_hi  = bus_wr && (bus_addr == OFF_CNT_HI);
        wr_cnt_ws  = bus_wr && (bus_addr == OFF_CNT_WS);
        wr_tgt_lo  = bus_wr && (bus_addr == OFF_TGT_LO);
        wr_tgt_hi  = bus_wr && (bus_addr == OFF_TGT_HI);
        wr_step    = bus_wr && (bus_addr == OFF_STEP);
        wr_ctrl    = bus_wr && (bus_addr == OFF_CTRL);
        wr_istat   = bus_wr && (bus_addr == OFF_ISTAT);
        wr_ien     = bus_wr && (bus_addr == OFF_IEN);
        wr_main_ws = bus_wr && (bus_addr == OFF_MAIN_WS);
    end

    // control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            auto_q <= 1'b0;
            cen_q  <= 1'b0;
        end else if (wr_ctrl) begin
            run_q  <= bus_wdata[CTL_RUN];
            auto_q <= bus_wdata[CTL_AUTO];
            cen_q  <= bus_wdata[CTL_CEN];
        end
    end

    // interrupt status: sticky on hit, write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) istat_q <= 1'b0;
        else        istat_q <= (istat_q & ~(wr_istat & bus_wdata[0])) | hit;
    end

    // interrupt enable
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= 1'b0;
        else if (wr_ien) ien_q <= bus_wdata[0];
    end

    gcmp_counter #(.DATA_W(DATA_W)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_q),
        .wr_lo (wr_cnt_lo),
        .wr_hi (wr_cnt_hi),
        .wdata (bus_wdata),
        .cnt   (cnt_q)
    );

    gcmp_compare #(.DATA_W(DATA_W)) u_compare (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (cnt_q),
        .enable   (cen_q),
        .auto_inc (auto_q),
        .wr_lo    (wr_tgt_lo),
        .wr_hi    (wr_tgt_hi),
        .wr_step  (wr_step),
        .wdata    (bus_wdata),
        .target   (tgt_q),
        .step     (step_q),
        .hit      (hit)
    );

    // acknowledge requests for the two write-status registers
    always_comb begin
        main_set            = '0;
        main_set[WS_CTRL]   = wr_ctrl;
        main_set[WS_TGT_LO] = wr_tgt_lo;
        main_set[WS_TGT_HI] = wr_tgt_hi;
        main_set[WS_STEP]   = wr_step;
        cnt_set             = '0;
        cnt_set[WS_CNT_LO]  = wr_cnt_lo;
        cnt_set[WS_CNT_HI]  = wr_cnt_hi;
    end

    gcmp_wstat #(.DATA_W(DATA_W)) u_main_ws (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_req  (main_set),
        .clr_wr   (wr_main_ws),
        .clr_mask (bus_wdata),
        .stat     (main_ws)
    );

    gcmp_wstat #(.DATA_W(DATA_W)) u_cnt_ws (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_req  (cnt_set),
        .clr_wr   (wr_cnt_ws),
        .clr_mask (bus_wdata),
        .stat     (cnt_ws)
    );

    // control register as seen on reads
    always_comb begin
        ctrl_view           = '0;
        ctrl_view[CTL_RUN]  = run_q;
        ctrl_view[CTL_AUTO] = auto_q;
        ctrl_view[CTL_CEN]  = cen_q;
    end

    // read multiplexer, zero for unmapped offsets
    always_comb begin
        case (bus_addr)
            OFF_CNT_LO:  bus_rdata = cnt_q[DATA_W-1:0];
            OFF_CNT_HI:  bus_rdata = cnt_q[CNT_W-1:DATA_W];
            OFF_CNT_WS:  bus_rdata = cnt_ws;
            OFF_TGT_LO:  bus_rdata = tgt_q[DATA_W-1:0];
            OFF_TGT_HI:  bus_rdata = tgt_q[CNT_W-1:DATA_W];
            OFF_STEP:    bus_rdata = step_q;
            OFF_CTRL:    bus_rdata = ctrl_view;
            OFF_ISTAT:   bus_rdata = {{(DATA_W-1){1'b0}}, istat_q};
            OFF_IEN:     bus_rdata = {{(DATA_W-1){1'b0}}, ien_q};
            OFF_MAIN_WS: bus_rdata = main_ws;
            default:     bus_rdata = '0;
        endcase
    end

    // interrupt output
    assign irq = istat_q & ien_q;
endmodule

// File: rtl/gcmp_timer_chk.sv
// Module: property checker for gcmp_timer, attached by bind.
// Assumes one access per cycle and a synchronous active-low reset.
module gcmp_timer_chk #(
    parameter int DATA_W = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_wr,
    input logic [gcmp_pkg::ADDR_W-1:0] bus_addr,
    input logic [2*DATA_W-1:0]         cnt,
    input logic [2*DATA_W-1:0]         tgt,
    input logic [DATA_W-1:0]           step,
    input logic                        run,
    input logic                        cen,
    input logic                        auto_inc,
    input logic                        istat,
    input logic                        ien,
    input logic                        irq,
    input logic [DATA_W-1:0]           main_ws
);
    import gcmp_pkg::*;

    logic cnt_wr, tgt_wr, ctrl_wr;
    assign cnt_wr  = bus_wr && (bus_addr == OFF_CNT_LO || bus_addr == OFF_CNT_HI);
    assign tgt_wr  = bus_wr && (bus_addr == OFF_TGT_LO || bus_addr == OFF_TGT_HI);
    assign ctrl_wr = bus_wr && (bus_addr == OFF_CTRL);

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_wr) |=> (cnt == $past(cnt) + 1'b1));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> (cnt == $past(cnt)));

    // R5
    hit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cen && cnt == tgt) |=> istat);

    // R6
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cen && auto_inc && cnt == tgt && !tgt_wr) |=>
        (tgt == $past(tgt) + (2*DATA_W)'($past(step))));

    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ien |-> !irq);

    // R9
    ctrl_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> ##1 main_ws[WS_CTRL]);
endmodule

bind gcmp_timer gcmp_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .cnt      (cnt_q),
    .tgt      (tgt_q),
    .step     (step_q),
    .run      (run_q),
    .cen      (cen_q),
    .auto_inc (auto_q),
    .istat    (istat_q),
    .ien      (ien_q),
    .irq      (irq),
    .main_ws  (main_ws)
);

// File: tb/gcmp_timer_bench.sv
// Bench: behavioural reference model compared every clock, plus directed checks.
module gcmp_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    gcmp_timer u_gcmp_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // reference state
    longint unsigned m_cnt, m_tgt;
    bit [31:0] m_step, m_wsm, m_wsc, m_pm, m_pc;
    bit m_run, m_auto, m_cen, m_is, m_ie;

    function automatic bit [31:0] m_read(input bit [11:0] a);
        case (a)
            12'h100: return m_cnt[31:0];
            12'h104: return m_cnt[63:32];
            12'h110: return m_wsc;
            12'h200: return m_tgt[31:0];
            12'h204: return m_tgt[63:32];
            12'h208: return m_step;
            12'h240: return {23'd0, m_run, 6'd0, m_auto, m_cen};
            12'h244: return {31'd0, m_is};
            12'h248: return {31'd0, m_ie};
            12'h24C: return m_wsm;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input bit [11:0] a);
        case (a)
            12'h100, 12'h104: return "R3";
            12'h200, 12'h204, 12'h208: return "R6";
            12'h240: return "R4";
            12'h244: return "R7";
            12'h248: return "R8";
            12'h110, 12'h24C: return "R10";
            default: return "R11";
        endcase
    endfunction

    // model update at each rising edge from the inputs held since the falling edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_tgt = 0; m_step = 0; m_wsm = 0; m_wsc = 0; m_pm = 0; m_pc = 0;
            m_run = 0; m_auto = 0; m_cen = 0; m_is = 0; m_ie = 0;
        end else begin
            bit match;
            bit [31:0] npm, npc;
            match = m_cen && (m_cnt == m_tgt);
            npm = 0; npc = 0;
            if (bus_wr && bus_addr == 12'h240) npm[16] = 1;
            if (bus_wr && bus_addr == 12'h200) npm[0] = 1;
            if (bus_wr && bus_addr == 12'h204) npm[1] = 1;
            if (bus_wr && bus_addr == 12'h208) npm[2] = 1;
            if (bus_wr && bus_addr == 12'h100) npc[0] = 1;
            if (bus_wr && bus_addr == 12'h104) npc[1] = 1;
            m_wsm = (m_wsm & ~((bus_wr && bus_addr == 12'h24C) ? bus_wdata : 32'd0)) | m_pm;
            m_wsc = (m_wsc & ~((bus_wr && bus_addr == 12'h110) ? bus_wdata : 32'd0)) | m_pc;
            m_pm = npm; m_pc = npc;
            if (bus_wr && (bus_addr == 12'h200 || bus_addr == 12'h204)) begin
                if (bus_addr == 12'h200) m_tgt[31:0] = bus_wdata;
                else                     m_tgt[63:32] = bus_wdata;
            end else if (match && m_auto) begin
                m_tgt = m_tgt + m_step;
            end
            if (bus_wr && (bus_addr == 12'h100 || bus_addr == 12'h104)) begin
                if (bus_addr == 12'h100) m_cnt[31:0] = bus_wdata;
                else                     m_cnt[63:32] = bus_wdata;
            end else if (m_run) begin
                m_cnt = m_cnt + 1;
            end
            m_is = (m_is && !(bus_wr && bus_addr == 12'h244 && bus_wdata[0])) || match;
            if (bus_wr && bus_addr == 12'h208) m_step = bus_wdata;
            if (bus_wr && bus_addr == 12'h248) m_ie = bus_wdata[0];
            if (bus_wr && bus_addr == 12'h240) begin
                m_run = bus_wdata[8]; m_auto = bus_wdata[1]; m_cen = bus_wdata[0];
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        end
    endtask

    // one bus cycle: compare with the model, then drive the next access
    task automatic cyc(input logic [11:0] a, input logic w, input logic [31:0] d);
        @(negedge clk);
        if (rst_n) begin
            chk(tag_of(bus_addr), bus_rdata, m_read(bus_addr));
            chk("R8", {31'd0, irq}, {31'd0, m_is & m_ie});
        end
        bus_addr = a; bus_wr = w; bus_wdata = d;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        cyc(a, 1'b0, 32'd0);
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(bus_addr, 1'b0, 32'd0);
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: all registers clear after reset
        rd(12'h100, 0, "R1"); rd(12'h104, 0, "R1"); rd(12'h200, 0, "R1");
        rd(12'h204, 0, "R1"); rd(12'h208, 0, "R1"); rd(12'h240, 0, "R1");
        rd(12'h244, 0, "R1"); rd(12'h248, 0, "R1"); rd(12'h24C, 0, "R1");
        rd(12'h110, 0, "R1");
        chk("R1", {31'd0, irq}, 32'd0);

        // R2: load both halves while stopped, value holds
        cyc(12'h100, 1, 32'hFFFF_FFFE);
        cyc(12'h104, 1, 32'd5);
        idle(3);
        rd(12'h100, 32'hFFFF_FFFE, "R2");
        rd(12'h104, 32'd5, "R2");

        // R9 / R10: counter write-status bits and partial clear
        rd(12'h110, 32'd3, "R9");
        cyc(12'h110, 1, 32'd1);
        rd(12'h110, 32'd2, "R10");
        cyc(12'h110, 1, 32'd2);
        rd(12'h110, 32'd0, "R10");

        // R4 / R9 / R3: start with junk bits, ack appears one cycle late, carry into upper half
        cyc(12'h240, 1, 32'hFFFF_FFFC);
        rd(12'h24C, 32'h0, "R9");
        rd(12'h24C, 32'h0001_0000, "R9");
        rd(12'h240, 32'h0000_0100, "R4");
        rd(12'h104, 32'd6, "R3");
        cyc(12'h24C, 1, 32'h0001_0000);
        rd(12'h24C, 32'h0, "R10");

        // R12: loading while running takes the value exactly
        cyc(12'h100, 1, 32'h20);
        rd(12'h100, 32'h20, "R12");
        rd(12'h104, 32'd6, "R12");

        // R5 / R6: periodic compare with interrupt masked
        cyc(12'h240, 1, 32'd0);
        cyc(12'h100, 1, 32'd0);
        cyc(12'h104, 1, 32'd0);
        cyc(12'h200, 1, 32'd10);
        cyc(12'h204, 1, 32'd0);
        cyc(12'h208, 1, 32'd7);
        cyc(12'h248, 1, 32'd0);
        cyc(12'h240, 1, 32'h103);
        idle(15);
        rd(12'h244, 32'd1, "R5");
        chk("R8", {31'd0, irq}, 32'd0);
        cyc(12'h240, 1, 32'h100);
        rd(12'h200, 32'd17, "R6");

        // R8: unmasking raises the line
        cyc(12'h248, 1, 32'd1);
        rd(12'h244, 32'd1, "R8");
        chk("R8", {31'd0, irq}, 32'd1);

        // R7: write-one clears status and line
        cyc(12'h244, 1, 32'd1);
        rd(12'h244, 32'd0, "R7");
        chk("R7", {31'd0, irq}, 32'd0);

        // R11: unmapped offsets
        rd(12'h300, 32'd0, "R11");
        rd(12'h10C, 32'd0, "R11");

        // R9 / R10: main write-status collects ctrl, target and step acks
        rd(12'h24C, 32'h0001_0007, "R9");
        cyc(12'h24C, 1, 32'h0001_0007);
        rd(12'h24C, 32'h0, "R10");

        idle(2);
        summary();
        $finish;
    end
endmodule